// File: doc/BRIEF.md
# Flash Status Register and Write Guard

This block keeps the status byte of a serial NOR flash command controller and decides whether a write may proceed. The command decoder hands it one-cycle strobes for write enable, write disable, status write (with its data byte) and security-ID lockout. The program/erase engine hands it one-cycle completion pulses, plus a busy flag and a flag that marks auto-increment programming mode. It also sees the active-low write-protect pin and the target byte address of the pending operation.

From these it builds the status byte returned by a status read, and three permission flags. The decoder and engine consult them before starting an operation: array write at the given address, chip erase, and security-ID write. The write-enable latch is set by an explicit command and cleared by nearly every operation that finishes. The protect field selects a top fraction of the 1 MiB array to guard. A lock bit can freeze that field while the protect pin is held low.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte reads 8'h1C with busy and mode inputs low: protect field 3'b111, lock bit 0, write-enable latch 0, security lock 0.
- R2: A write-enable strobe sets the latch (status bit 1) on the next cycle only when busy_in is low. With busy_in high it leaves the latch at 0.
- R3: A write-disable strobe, a status-write strobe, or any bit of done_vec clears the latch on the next cycle. A clear wins over a write-enable strobe in the same cycle.
- R4: While the latch is 0, wr_ok, chip_erase_ok and sid_wr_ok are all 0.
- R5: A lockout strobe sets the security lock (status bit 5) on the next cycle. Only reset clears it. While it is 1, sid_wr_ok is 0.
- R6: A status write accepted with the latch at 1 loads wrsr_data[4:2] into the protect field and wrsr_data[7] into the lock bit, if wp_n is high or the lock bit is 0. If the lock bit is 1 and wp_n is low, both stay unchanged. A status write with the latch at 0 changes nothing.
- R7: Addresses are protected by field value: 000 none; 001 F0000h-FFFFFh; 010 E0000h-FFFFFh; 011 C0000h-FFFFFh; 100 80000h-FFFFFh; 101, 110 and 111 the whole array. wr_ok is 1 only for an unprotected address.
- R8: chip_erase_ok is 1 only when the protect field is 000, the latch is 1 and busy_in is low.
- R9: Status layout: bit0 busy_in, bit1 latch, bits 4:2 protect field (bit 4 most significant), bit5 security lock, bit6 aai_in, bit7 lock bit. Bits 0 and 6 follow their inputs in the same cycle.
- R10: While busy_in is high, wr_ok, chip_erase_ok and sid_wr_ok are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_sid_lock | input | 1 | Security-ID lockout strobe |
| done_vec | input | NUM_DONE | Completion pulses of program, erase and ID operations |
| busy_in | input | 1 | Internal operation in progress |
| aai_in | input | 1 | Auto-increment programming mode active |
| wp_n | input | 1 | Write-protect pin, active low |
| addr | input | ADDR_W | Target byte address |
| status | output | 8 | Status byte |
| wr_ok | output | 1 | Array write allowed at addr |
| chip_erase_ok | output | 1 | Chip erase allowed |
| sid_wr_ok | output | 1 | Security-ID write allowed |

## Verification
Each state bit of the block appears directly in the status byte, so a wrong latch, protect field, lock bit or security lock shows at the port one cycle after the strobe that caused it. The permission flags are combinational on that state and on addr. A bad protect field or a wrong boundary in the range decode therefore shows as a wrong wr_ok or chip_erase_ok in the same cycle the address is presented. The stimulus targets the addresses just inside and just outside each boundary, and the clear-over-set and pin-gated lock cases, where a slip is otherwise silent.

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W   = 20,
  parameter int NUM_DONE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_sid_lock,
  input  logic [NUM_DONE-1:0] done_vec,
  input  logic              busy_in,
  input  logic              aai_in,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status,
  output logic              wr_ok,
  output logic              chip_erase_ok,
  output logic              sid_wr_ok
);

  localparam logic [ADDR_W-1:0] ALL1   = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LOW_16 = ALL1 >> 4;
  localparam logic [ADDR_W-1:0] LOW_8  = ALL1 >> 3;
  localparam logic [ADDR_W-1:0] LOW_4  = ALL1 >> 2;
  localparam logic [ADDR_W-1:0] LOW_2  = ALL1 >> 1;

  logic       wel_q, sec_q, lock_q;
  logic [2:0] prot_q;
  logic       in_prot;

  wire wel_clr   = cmd_wrdi | cmd_wrsr | (|done_vec);
  wire prot_load = cmd_wrsr & wel_q & (wp_n | ~lock_q);
  wire can_go    = wel_q & ~busy_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      sec_q  <= 1'b0;
      lock_q <= 1'b0;
      prot_q <= 3'b111;
    end else begin
      if (wel_clr)                 wel_q <= 1'b0;
      else if (cmd_wren && !busy_in) wel_q <= 1'b1;
      if (cmd_sid_lock) sec_q <= 1'b1;
      if (prot_load) begin
        prot_q <= wrsr_data[4:2];
        lock_q <= wrsr_data[7];
      end
    end
  end

  always_comb begin
    case (prot_q)
      3'd0:    in_prot = 1'b0;
      3'd1:    in_prot = &(addr | LOW_16);
      3'd2:    in_prot = &(addr | LOW_8);
      3'd3:    in_prot = &(addr | LOW_4);
      3'd4:    in_prot = &(addr | LOW_2);
      default: in_prot = 1'b1;
    endcase
  end

  assign status        = {lock_q, aai_in, sec_q, prot_q, wel_q, busy_in};
  assign wr_ok         = can_go & ~in_prot;
  assign chip_erase_ok = can_go & (prot_q == 3'd0);
  assign sid_wr_ok     = can_go & ~sec_q;

endmodule

module flash_status_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_wrsr,
  input logic       busy_in,
  input logic       wp_n,
  input logic [7:0] status,
  input logic       wr_ok,
  input logic       chip_erase_ok,
  input logic       sid_wr_ok
);

  assert_wren_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && busy_in && !status[1]) |=> !status[1]);

  assert_wel_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrdi || cmd_wrsr) |=> !status[1]);

  assert_no_wel_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !status[1] |-> (!wr_ok && !chip_erase_ok && !sid_wr_ok));

  assert_sec_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |=> status[5]);

  assert_sec_blocks_sid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> !sid_wr_ok);

  assert_lock_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |=> ($stable(status[4:2]) && status[7]));

  assert_chip_erase_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_ok |-> (status[4:2] == 3'b000));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> (!wr_ok && !chip_erase_ok && !sid_wr_ok));

endmodule

bind flash_status_guard flash_status_guard_chk chk_i (.*);

// File: tb/flash_status_guard_tb.sv
`timescale 1ns/1ps
module flash_status_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_sid_lock = 0;
  logic [7:0]  wrsr_data = 8'h00;
  logic [6:0]  done_vec = '0;
  logic        busy_in = 0, aai_in = 0, wp_n = 1;
  logic [19:0] addr = '0;
  logic [7:0]  status;
  logic        wr_ok, chip_erase_ok, sid_wr_ok;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  flash_status_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_sid_lock(cmd_sid_lock),
    .done_vec(done_vec), .busy_in(busy_in), .aai_in(aai_in), .wp_n(wp_n),
    .addr(addr), .status(status), .wr_ok(wr_ok),
    .chip_erase_ok(chip_erase_ok), .sid_wr_ok(sid_wr_ok));

  // {field, address, expected wr_ok}
  localparam logic [23:0] VEC [13] = '{
    {3'd0, 20'hFFFFF, 1'b1}, {3'd1, 20'hFFFFF, 1'b0}, {3'd1, 20'hEFFFF, 1'b1},
    {3'd2, 20'hE0000, 1'b0}, {3'd2, 20'hDFFFF, 1'b1}, {3'd3, 20'hC0000, 1'b0},
    {3'd3, 20'hBFFFF, 1'b1}, {3'd4, 20'h80000, 1'b0}, {3'd4, 20'h7FFFF, 1'b1},
    {3'd5, 20'h00000, 1'b0}, {3'd6, 20'h12345, 1'b0}, {3'd7, 20'h00000, 1'b0},
    {3'd0, 20'h00000, 1'b1}};

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wren();
    cmd_wren = 1; @(negedge clk); cmd_wren = 0;
  endtask

  task automatic wrsr(input logic [7:0] d);
    cmd_wrsr = 1; wrsr_data = d; @(negedge clk); cmd_wrsr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk(status, 8'h1C, "R1 reset status");
    chk(wr_ok, 0, "R4 no write after reset");

    // protect decode table
    foreach (VEC[i]) begin
      wren(); wrsr({3'b000, VEC[i][23:21], 2'b00});
      chk(status[4:2], VEC[i][23:21], "R6 field load");
      chk(status[1], 0, "R3 status write clears latch");
      wren(); addr = VEC[i][20:1]; #1;
      chk(wr_ok, VEC[i][0], "R7 range decode");
      chk(chip_erase_ok, VEC[i][23:21] == 3'd0, "R8 chip erase gate");
      cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0;
      chk(status[1], 0, "R3 write disable");
    end

    // busy gating and layout
    busy_in = 1; aai_in = 1; wren(); #1;
    chk(status[1], 0, "R2 enable ignored while busy");
    chk({status[6], status[0]}, 2'b11, "R9 busy and mode bits");
    busy_in = 0; aai_in = 0; wren();
    chk(status[1], 1, "R2 enable sets latch");
    busy_in = 1; addr = 20'h00000; #1;
    chk({wr_ok, chip_erase_ok, sid_wr_ok}, 3'b000, "R10 busy blocks all");
    busy_in = 0; #1;
    chk(wr_ok, 1, "R10 released");
    done_vec = 7'b0010000; @(negedge clk); done_vec = '0;
    chk(status[1], 0, "R3 completion pulse clears");
    cmd_wren = 1; done_vec = 7'b0000001; @(negedge clk); cmd_wren = 0; done_vec = '0;
    chk(status[1], 0, "R3 clear wins over enable");
    cmd_wren = 1; cmd_wrdi = 1; @(negedge clk); cmd_wren = 0; cmd_wrdi = 0;
    chk(status[1], 0, "R3 disable wins over enable");
    #1 chk({wr_ok, chip_erase_ok, sid_wr_ok}, 3'b000, "R4 latch low blocks all");

    // status write without latch
    wrsr(8'h00);
    chk(status[4:2], 3'd0, "R6 prior field kept");
    wren(); wrsr(8'h14);
    chk(status[4:2], 3'd5, "R6 field loaded");
    wrsr(8'h00);
    chk(status[4:2], 3'd5, "R6 write without latch ignored");

    // lock bit with protect pin
    wren(); wrsr(8'h80);
    chk({status[7], status[4:2]}, 4'b1000, "R6 lock set");
    wp_n = 0; wren(); wrsr(8'h1C);
    chk({status[7], status[4:2]}, 4'b1000, "R6 frozen while pin low");
    wp_n = 1; wren(); wrsr(8'h0C);
    chk({status[7], status[4:2]}, 4'b0011, "R6 pin high overrides lock");

    // security lock
    wren(); #1;
    chk(sid_wr_ok, 1, "R5 ID write allowed before lock");
    cmd_sid_lock = 1; @(negedge clk); cmd_sid_lock = 0;
    chk(status[5], 1, "R5 security lock set");
    chk(sid_wr_ok, 0, "R5 ID write blocked");
    wrsr(8'h00); wren(); repeat (5) @(negedge clk);
    chk(status[5], 1, "R5 lock persists");
    do_reset();
    chk(status, 8'h1C, "R1 reset clears security lock");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule